// File: doc/BRIEF.md
# Coin-Counting Release Controller

This block tracks money inserted into a drink dispenser that charges fifteen cents. Two coin sensors each give a one-cycle pulse, one for a five-cent coin and one for a ten-cent coin. The block adds up credit in five-cent steps and opens the release mechanism once fifteen cents or more has been paid. It gives no change: a ten-cent coin inserted at ten cents is accepted, and the extra five cents is lost.

Credit is held in a one-hot register with one flip-flop for each credit level (0, 5, 10, 15 cents). The release line is the flip-flop for the highest level, so no logic sits between that flip-flop and the output. Once the register reaches the highest level it stays there for all further coins. Only a reset clears it. The number of levels is a parameter. A five-cent coin moves the credit up one level, a ten-cent coin moves it up two levels, and the credit stops at the top level.

Top module: `vend_ctrl`

## Requirements
- R1: Reset is synchronous and active-low. After a clock edge with `rst_n` low, `release_open` is 0 and the credit is zero, so a later payment must add up to the full fifteen cents before the release opens.
- R2: In a cycle with no coin pulse, the credit does not change, and `release_open` keeps its value.
- R3: At zero credit, a five-cent pulse takes the credit to 5 cents.
- R4: At zero credit, a ten-cent pulse takes the credit to 10 cents.
- R5: At 5 cents, a five-cent pulse takes the credit to 10 cents, and a ten-cent pulse takes it to 15 cents.
- R6: At 10 cents, either coin takes the credit to 15 cents. Any overpayment is kept and no change is given.
- R7: `release_open` becomes 1 on the clock edge that samples the coin pulse bringing the credit to 15 cents.
- R8: At 15 cents, the credit and `release_open` = 1 stay unchanged for any coin input, until a reset clears them.
- R9: When both coin pulses are high in the same cycle, only the ten-cent coin is counted.
- R10: Exactly one credit flip-flop is set at all times after reset. `release_open` is 0 at every credit below 15 cents.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| coin_nickel | input | 1 | One-cycle pulse for a five-cent coin |
| coin_dime | input | 1 | One-cycle pulse for a ten-cent coin |
| release_open | output | 1 | Opens the release mechanism; driven directly by the top credit flip-flop |

## Verification
The assertions assume that each coin pulse lasts exactly one cycle, so one insertion never counts twice. They also assume the register leaves reset before any coin is applied. The pulse-width assumption matters because the block has no edge detector. The bench drives each coin high for a single clock cycle and sets it low before the next edge. The one case where both coins are high together is applied on purpose, to check the priority rule.

// File: rtl/vend_pkg.sv
// Package vend_pkg
// Shared coin classification used by the decoder and the next-state logic.
// Assumes at most one classification per cycle.
package vend_pkg;
    typedef enum logic [1:0] {
        COIN_NONE   = 2'd0,
        COIN_NICKEL = 2'd1,
        COIN_DIME   = 2'd2
    } coin_e;
endpackage

// File: rtl/vend_coin_decode.sv
// Module vend_coin_decode
// Turns the two coin sensor pulses into one coin classification.
// Assumes each pulse is one cycle wide.
// If both pulses are high together, the ten-cent coin wins (R9).
module vend_coin_decode
    import vend_pkg::*;
(
    input  logic  nickel_i,
    input  logic  dime_i,
    output coin_e coin_o
);
    // Pick the coin with priority to the ten-cent sensor.
    always_comb begin
        if (dime_i)        coin_o = COIN_DIME;
        else if (nickel_i) coin_o = COIN_NICKEL;
        else               coin_o = COIN_NONE;
    end
endmodule

// File: rtl/vend_next_state.sv
// Module vend_next_state
// Computes the next one-hot credit level.
// A five-cent coin moves the credit up one level, a ten-cent coin moves it up two.
// The credit stops at the top level, and the top level absorbs all further coins.
// Assumes cur_i is one-hot and LEVELS is at least 3.
module vend_next_state
    import vend_pkg::*;
#(
    parameter int LEVELS = 4
) (
    input  logic [LEVELS-1:0] cur_i,
    input  coin_e             coin_i,
    output logic [LEVELS-1:0] nxt_o
);
    localparam int TOP = LEVELS - 1;

    logic is_none, is_n, is_d;

    // Split the coin classification into one flag per coin.
    always_comb begin
        is_none = (coin_i == COIN_NONE);
        is_n    = (coin_i == COIN_NICKEL);
        is_d    = (coin_i == COIN_DIME);
    end

    for (genvar k = 0; k < LEVELS; k++) begin : g_lvl
        logic from_n, from_d;
        if (k >= 1) begin : g_fn
            assign from_n = cur_i[k-1] & is_n;
        end else begin : g_fn0
            assign from_n = 1'b0;
        end
        if (k >= 2) begin : g_fd
            assign from_d = cur_i[k-2] & is_d;
        end else begin : g_fd0
            assign from_d = 1'b0;
        end
        if (k == TOP) begin : g_top
            // Top level: stay here, or arrive by any coin including overpayment.
            assign nxt_o[k] = cur_i[k] | from_n | from_d | (cur_i[k-1] & is_d);
        end else begin : g_mid
            // Lower level: stay while idle, or arrive from below.
            assign nxt_o[k] = (cur_i[k] & is_none) | from_n | from_d;
        end
    end
endmodule

// File: rtl/vend_state_reg.sv
// Module vend_state_reg
// One-hot credit register with a synchronous active-low reset that loads the zero-credit level.
// Assumes its next-state input is one-hot whenever reset is released.
module vend_state_reg #(
    parameter int LEVELS = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [LEVELS-1:0] d_i,
    output logic [LEVELS-1:0] q_o
);
    // Register the credit level, or load zero credit during reset.
    always_ff @(posedge clk) begin
        if (!rst_n) q_o <= LEVELS'(1);
        else        q_o <= d_i;
    end

    // R10: exactly one credit flip-flop is set at all times after reset.
    assert_state_onehot_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot(q_o));

    // R1: a reset edge leaves only the zero-credit flip-flop set.
    assert_reset_zero_R1: assert property (@(posedge clk)
        !rst_n |=> (q_o == LEVELS'(1)));
endmodule

// File: rtl/vend_ctrl.sv
// Module vend_ctrl
// Top of the coin-counting release controller.
// Assumes single-cycle coin pulses.
// The release line is the top credit flip-flop itself.
module vend_ctrl
    import vend_pkg::*;
#(
    parameter int LEVELS = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic coin_nickel,
    input  logic coin_dime,
    output logic release_open
);
    localparam int TOP = LEVELS - 1;

    coin_e             coin;
    logic [LEVELS-1:0] credit_q;
    logic [LEVELS-1:0] credit_d;

    vend_coin_decode u_dec (
        .nickel_i (coin_nickel),
        .dime_i   (coin_dime),
        .coin_o   (coin)
    );

    vend_next_state #(.LEVELS(LEVELS)) u_nxt (
        .cur_i  (credit_q),
        .coin_i (coin),
        .nxt_o  (credit_d)
    );

    vend_state_reg #(.LEVELS(LEVELS)) u_reg (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   (credit_d),
        .q_o   (credit_q)
    );

    // Drive the release line straight from the top credit flip-flop.
    assign release_open = credit_q[TOP];

    // R2: with no coin pulse, the credit holds.
    assert_idle_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!coin_nickel && !coin_dime) |=> $stable(credit_q));

    // R8: once open, the release stays open until reset.
    assert_open_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
        release_open |=> release_open);

    // R9: when both coins arrive at zero credit, only the ten-cent coin counts.
    assert_dime_priority_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (credit_q[0] && coin_nickel && coin_dime) |=> credit_q[2]);

    // R5: at 5 cents, a five-cent coin alone takes the credit to 10 cents.
    assert_five_plus_nickel_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (credit_q[1] && coin_nickel && !coin_dime) |=> credit_q[2]);

    // R6: at 10 cents, any coin opens the release.
    assert_ten_any_coin_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (credit_q[TOP-1] && (coin_nickel || coin_dime)) |=> release_open);
endmodule

// File: tb/vend_ctrl_tb_top.sv
// Directed bench for vend_ctrl: one task per scenario, each checking its own results.
module vend_ctrl_tb_top;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic coin_nickel = 1'b0;
    logic coin_dime = 1'b0;
    logic release_open;
    int   n_checks = 0;
    int   n_fails = 0;
    bit   done = 1'b0;

    always #2.5 clk = ~clk;

    vend_ctrl dut_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .coin_nickel  (coin_nickel),
        .coin_dime    (coin_dime),
        .release_open (release_open)
    );

    // Compare release_open with the expected value and log any mismatch.
    task automatic check(input logic exp, input string req);
        n_checks++;
        if (release_open !== exp) begin
            n_fails++;
            $display("FAIL %s: release_open=%b expected=%b", req, release_open, exp);
        end
    endtask

    // Drive one cycle of coin inputs, then sample just after the capturing edge.
    task automatic step(input logic n, input logic d);
        @(negedge clk);
        coin_nickel = n;
        coin_dime   = d;
        @(posedge clk);
        #1;
        @(negedge clk);
        coin_nickel = 1'b0;
        coin_dime   = 1'b0;
    endtask

    // Apply a reset for one edge.
    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        @(posedge clk);
        #1;
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic t_reset_state();
        do_reset();
        check(1'b0, "R1 reset state");
    endtask

    task automatic t_idle();
        do_reset();
        for (int i = 0; i < 4; i++) begin
            step(1'b0, 1'b0);
            check(1'b0, "R2 idle at zero");
        end
        step(1'b1, 1'b0);
        step(1'b0, 1'b0);
        step(1'b0, 1'b0);
        step(1'b0, 1'b1);
        check(1'b1, "R2 idle kept 5 cents, dime opens");
        step(1'b0, 1'b0);
        check(1'b1, "R2 idle keeps open");
    endtask

    task automatic t_nickels();
        do_reset();
        step(1'b1, 1'b0);
        check(1'b0, "R3 R10 5 cents closed");
        step(1'b1, 1'b0);
        check(1'b0, "R5 R10 10 cents closed");
        step(1'b1, 1'b0);
        check(1'b1, "R6 R7 third nickel opens");
    endtask

    task automatic t_dime_first();
        do_reset();
        step(1'b0, 1'b1);
        check(1'b0, "R4 10 cents closed");
        step(1'b1, 1'b0);
        check(1'b1, "R6 nickel at 10 opens");
    endtask

    task automatic t_nickel_dime();
        do_reset();
        step(1'b1, 1'b0);
        step(1'b0, 1'b1);
        check(1'b1, "R5 R7 dime at 5 opens");
    endtask

    task automatic t_overpay();
        do_reset();
        step(1'b0, 1'b1);
        step(1'b0, 1'b1);
        check(1'b1, "R6 overpay opens");
    endtask

    task automatic t_absorb();
        do_reset();
        step(1'b0, 1'b1);
        step(1'b0, 1'b1);
        step(1'b1, 1'b0);
        check(1'b1, "R8 nickel at 15");
        step(1'b0, 1'b1);
        check(1'b1, "R8 dime at 15");
        step(1'b1, 1'b1);
        check(1'b1, "R8 both at 15");
        do_reset();
        check(1'b0, "R1 reset clears 15");
    endtask

    task automatic t_both();
        do_reset();
        step(1'b1, 1'b1);
        check(1'b0, "R9 both at zero counts dime only");
        step(1'b1, 1'b0);
        check(1'b1, "R9 then nickel opens");
        do_reset();
        step(1'b1, 1'b0);
        step(1'b1, 1'b1);
        check(1'b1, "R9 both at 5 counts dime");
    endtask

    task automatic t_reset_mid();
        do_reset();
        step(1'b1, 1'b0);
        do_reset();
        step(1'b0, 1'b1);
        check(1'b0, "R1 credit cleared mid-payment");
        step(1'b1, 1'b0);
        check(1'b1, "R1 full price after reset");
    endtask

    initial begin
        t_reset_state();
        t_idle();
        t_nickels();
        t_dime_first();
        t_nickel_dime();
        t_overpay();
        t_absorb();
        t_both();
        t_reset_mid();
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog: run did not complete, expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
            $finish;
        end
    end
endmodule